// File: doc/BRIEF.md
# Outer Program Bank Override Register

This block extends an indexed bank controller with a mode register that sits in the low address range. The mode register can take over the four 8 KB program ROM windows. A CPU write to 0x5000 loads the mode register. A write to the even register of the 0x8000/0x8001 pair selects which bank register the next odd-register write targets. Writes elsewhere in 0x5001–0x5FFF go to a small scratch RAM. That RAM has its own registered read port.

Depending on two mode bits, the program windows take one of three forms. They can be a 32 KB aligned run of four consecutive banks. They can be a 16 KB aligned pair in the upper half only. Or they can fall back to the stored bank registers 6 and 7, with the last two banks fixed on top. While the 32 KB form is active, ordinary program bank writes do not move the windows. Those writes are still remembered, so a later fallback uses them. Every bank number is reduced to the configured program ROM size. The block also keeps the eight character slot values that the select writes load.

Top module: `prg_override_ctl`

## Requirements
- R1: One clock edge with `rst` high puts the windows at banks PRG_BANKS-4, PRG_BANKS-3, PRG_BANKS-2 and PRG_BANKS-1 (slots 0 to 3). All eight character slots become 0, and the select and mode state are cleared.
- R2: If bits 7 and 5 of the mode are not both set, an odd-register write with select value 6 loads window 0 and one with select value 7 loads window 1. The value is the written byte modulo PRG_BANKS. The window changes on the edge that takes the write.
- R3: A write to 0x5000 with data bits 7 and 5 both set makes window i equal to ((data & 0x1E) << 1) + i, for i from 0 to 3.
- R4: A write to 0x5000 with bit 7 set and bit 5 clear sets window 2 to (data & 0x1F) << 1 and window 3 to that value plus one. Windows 0 and 1 keep their values.
- R5: A write to 0x5000 with bit 7 clear loads windows 0 and 1 from the last data written with select values 6 and 7. It sets windows 2 and 3 to PRG_BANKS-2 and PRG_BANKS-1.
- R6: While mode bits 7 and 5 are both set, odd-register writes with select 6 or 7 leave every window unchanged. Their data is still recorded for use by R5.
- R7: A write to 0x5001–0x5FFF stores the byte in scratch RAM at address bits [SCR_AW-1:0]. The byte can be read back one clock after `scr_rd_addr` is presented. Such a write changes no window and no character slot, whatever its data.
- R8: An odd-register write with select value 0 sets slot 4 to 0x100 + (data & 0xFE) and slot 5 to that value plus one. Select value 1 does the same for slots 6 and 7.
- R9: Odd-register writes with select values 2, 3, 4 and 5 load character slots 0, 1, 2 and 3 with the unmodified byte.
- R10: Register pair decoding uses address bits 15:13 and bit 0 only. Any address in 0x8000–0x9FFF acts as the select register when even and as the data register when odd. Only bits 2:0 of the select byte are used, and writes at or above 0xA000 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| scr_rd_addr | input | SCR_AW | Scratch RAM read address |
| scr_rd_data | output | 8 | Scratch RAM read data, registered |
| prg_win | output | 4 x log2(PRG_BANKS) | Bank numbers of the four 8 KB program windows, index 0 lowest |
| chr_slot | output | 8 x 9 | Character slot bank values, index 0 first |

## Verification
The bench goes after the mode transitions and the write lock. A design that gated the shadow record along with the window update would lose the bytes written during the lock, and a later fallback would show stale banks instead of them. A 16 KB override that also rewrote the lower windows, or a 32 KB base that kept data bit 0, would misplace the windows. The bench also aims a scratch write carrying a mode-like byte at the low range. A decoder that matched only the upper address bits would treat that write as a mode change. Register pair writes at aliased addresses, and pair values with the low bit set, catch a decoder that compares the full address and a character pair that is not forced even.

// File: rtl/prg_ovr_pkg.sv
package prg_ovr_pkg;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_MODE,
    WK_SCRATCH,
    WK_SELECT,
    WK_DATA
  } wr_kind_e;

  localparam logic [15:0] LOW_MASK  = 16'hF000;
  localparam logic [15:0] LOW_BASE  = 16'h5000;
  localparam logic [15:0] MODE_ADDR = 16'h5000;
  localparam logic [15:0] PAIR_MASK = 16'hE001;
  localparam logic [15:0] SEL_ADDR  = 16'h8000;
  localparam logic [15:0] DAT_ADDR  = 16'h8001;

  localparam int MODE_ON_BIT   = 7;
  localparam int MODE_WIDE_BIT = 5;

  localparam int NUM_WIN   = 4;
  localparam int NUM_CHR   = 8;
  localparam int CHR_W     = 9;
  localparam int SEL_W     = 3;

  localparam logic [SEL_W-1:0] SEL_LO_WIN = 3'd6;
  localparam logic [SEL_W-1:0] SEL_HI_WIN = 3'd7;

endpackage

// File: rtl/prg_ovr_decode.sv
module prg_ovr_decode
  import prg_ovr_pkg::*;
(
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  output wr_kind_e    kind
);

  always_comb begin
    kind = WK_NONE;
    if (wr_en) begin
      if ((wr_addr & LOW_MASK) == LOW_BASE) begin
        kind = (wr_addr == MODE_ADDR) ? WK_MODE : WK_SCRATCH;
      end else if ((wr_addr & PAIR_MASK) == SEL_ADDR) begin
        kind = WK_SELECT;
      end else if ((wr_addr & PAIR_MASK) == DAT_ADDR) begin
        kind = WK_DATA;
      end
    end
  end

endmodule

// File: rtl/prg_ovr_bank_regs.sv
module prg_ovr_bank_regs
  import prg_ovr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  wr_kind_e                      kind,
  input  logic [7:0]                    wr_data,
  output logic [SEL_W-1:0]              sel_q,
  output logic [7:0]                    shadow_lo,
  output logic [7:0]                    shadow_hi,
  output logic [NUM_CHR-1:0][CHR_W-1:0] chr_q
);

  logic data_wr;
  assign data_wr = (kind == WK_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (kind == WK_SELECT) begin
      sel_q <= wr_data[SEL_W-1:0];
    end
  end

  // Odd-register writes for selects 6 and 7 are always recorded,
  // independent of the override lock.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_lo <= '0;
      shadow_hi <= '0;
    end else if (data_wr) begin
      if (sel_q == SEL_LO_WIN) shadow_lo <= wr_data;
      if (sel_q == SEL_HI_WIN) shadow_hi <= wr_data;
    end
  end

  genvar j;
  generate
    for (j = 0; j < NUM_CHR; j++) begin : g_chr
      logic                 hit;
      logic [CHR_W-1:0]     val;
      if (j < 4) begin : g_single
        // slots 0..3 take select values 2..5 directly
        assign hit = data_wr && (sel_q == SEL_W'(j + 2));
        assign val = {1'b0, wr_data};
      end else begin : g_pair
        // slots 4..7 take an even pair from select 0 or 1, offset 0x100
        assign hit = data_wr && (sel_q == SEL_W'((j - 4) / 2));
        assign val = {1'b1, wr_data[7:1], 1'(j % 2)};
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          chr_q[j] <= '0;
        end else if (hit) begin
          chr_q[j] <= val;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/prg_ovr_map.sv
module prg_ovr_map
  import prg_ovr_pkg::*;
#(
  parameter int PRG_BANKS = 64,
  localparam int BW = $clog2(PRG_BANKS)
)(
  input  logic                       clk,
  input  logic                       rst,
  input  wr_kind_e                   kind,
  input  logic [7:0]                 wr_data,
  input  logic [SEL_W-1:0]           sel_q,
  input  logic [7:0]                 shadow_lo,
  input  logic [7:0]                 shadow_hi,
  output logic [NUM_WIN-1:0][BW-1:0] win_q
);

  logic mode_on_q;
  logic mode_wide_q;
  logic locked;
  logic [NUM_WIN-1:0][BW-1:0] win_nxt;

  function automatic logic [BW-1:0] fit(input logic [9:0] v);
    logic [31:0] w;
    w = {22'd0, v};
    return w[BW-1:0];
  endfunction

  assign locked = mode_on_q && mode_wide_q;

  always_comb begin
    win_nxt = win_q;
    unique case (kind)
      WK_MODE: begin
        if (wr_data[MODE_ON_BIT]) begin
          if (wr_data[MODE_WIDE_BIT]) begin
            for (int i = 0; i < NUM_WIN; i++) begin
              win_nxt[i] = fit({4'd0, wr_data[4:1], 2'(i)});
            end
          end else begin
            win_nxt[2] = fit({4'd0, wr_data[4:0], 1'b0});
            win_nxt[3] = fit({4'd0, wr_data[4:0], 1'b1});
          end
        end else begin
          win_nxt[0] = fit({2'd0, shadow_lo});
          win_nxt[1] = fit({2'd0, shadow_hi});
          win_nxt[2] = BW'(PRG_BANKS - 2);
          win_nxt[3] = BW'(PRG_BANKS - 1);
        end
      end
      WK_DATA: begin
        if (!locked) begin
          if (sel_q == SEL_LO_WIN) win_nxt[0] = fit({2'd0, wr_data});
          if (sel_q == SEL_HI_WIN) win_nxt[1] = fit({2'd0, wr_data});
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_on_q   <= 1'b0;
      mode_wide_q <= 1'b0;
    end else if (kind == WK_MODE) begin
      mode_on_q   <= wr_data[MODE_ON_BIT];
      mode_wide_q <= wr_data[MODE_WIDE_BIT];
    end
  end

  genvar k;
  generate
    for (k = 0; k < NUM_WIN; k++) begin : g_win
      always_ff @(posedge clk) begin
        if (rst) begin
          win_q[k] <= BW'(PRG_BANKS - NUM_WIN + k);
        end else begin
          win_q[k] <= win_nxt[k];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/prg_ovr_scratch.sv
module prg_ovr_scratch
  import prg_ovr_pkg::*;
#(
  parameter int SCR_AW = 10,
  localparam int DEPTH = 1 << SCR_AW
)(
  input  logic              clk,
  input  wr_kind_e          kind,
  input  logic [SCR_AW-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [SCR_AW-1:0] rd_idx,
  output logic [7:0]        rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (kind == WK_SCRATCH) begin
      mem[wr_idx] <= wr_data;
    end
    rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/prg_override_ctl.sv
module prg_override_ctl
  import prg_ovr_pkg::*;
#(
  parameter int PRG_BANKS = 64,
  parameter int SCR_AW    = 10,
  localparam int BW = $clog2(PRG_BANKS)
)(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [15:0]                   wr_addr,
  input  logic [7:0]                    wr_data,
  input  logic [SCR_AW-1:0]             scr_rd_addr,
  output logic [7:0]                    scr_rd_data,
  output logic [NUM_WIN-1:0][BW-1:0]    prg_win,
  output logic [NUM_CHR-1:0][CHR_W-1:0] chr_slot
);

  wr_kind_e         kind;
  logic [SEL_W-1:0] sel_q;
  logic [7:0]       shadow_lo;
  logic [7:0]       shadow_hi;

  prg_ovr_decode u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .kind    (kind)
  );

  prg_ovr_bank_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .wr_data   (wr_data),
    .sel_q     (sel_q),
    .shadow_lo (shadow_lo),
    .shadow_hi (shadow_hi),
    .chr_q     (chr_slot)
  );

  prg_ovr_map #(.PRG_BANKS(PRG_BANKS)) u_map (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .wr_data   (wr_data),
    .sel_q     (sel_q),
    .shadow_lo (shadow_lo),
    .shadow_hi (shadow_hi),
    .win_q     (prg_win)
  );

  prg_ovr_scratch #(.SCR_AW(SCR_AW)) u_scr (
    .clk     (clk),
    .kind    (kind),
    .wr_idx  (wr_addr[SCR_AW-1:0]),
    .wr_data (wr_data),
    .rd_idx  (scr_rd_addr),
    .rd_data (scr_rd_data)
  );

endmodule

// File: rtl/prg_override_chk.sv
module prg_override_chk #(
  parameter int PRG_BANKS = 64,
  localparam int BW = $clog2(PRG_BANKS)
)(
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic [15:0]          wr_addr,
  input logic [7:0]           wr_data,
  input logic [3:0][BW-1:0]   prg_win,
  input logic [7:0][8:0]      chr_slot,
  input logic                 mode_on,
  input logic                 mode_wide,
  input logic [2:0]           sel_q
);

  logic mode_wr, data_wr, scr_wr;
  assign mode_wr = wr_en && (wr_addr == 16'h5000);
  assign data_wr = wr_en && ((wr_addr & 16'hE001) == 16'h8001);
  assign scr_wr  = wr_en && ((wr_addr & 16'hF000) == 16'h5000) && (wr_addr != 16'h5000);

  // R1
  reset_windows_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (prg_win[0] == BW'(PRG_BANKS - 4)) && (prg_win[3] == BW'(PRG_BANKS - 1)));

  // R3
  wide_mode_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr && wr_data[7] && wr_data[5] |=>
      (prg_win[1] == BW'(prg_win[0] + 1)) && (prg_win[2] == BW'(prg_win[0] + 2)) &&
      (prg_win[3] == BW'(prg_win[0] + 3)) && (prg_win[0][1:0] == 2'b00));

  // R4
  half_mode_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr && wr_data[7] && !wr_data[5] |=>
      (prg_win[3] == BW'(prg_win[2] + 1)) && !prg_win[2][0] &&
      $stable(prg_win[0]) && $stable(prg_win[1]));

  // R5
  fallback_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr && !wr_data[7] |=>
      (prg_win[2] == BW'(PRG_BANKS - 2)) && (prg_win[3] == BW'(PRG_BANKS - 1)));

  // R6
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr && (sel_q[2:1] == 2'b11) && mode_on && mode_wide |=> $stable(prg_win));

  // R7
  scratch_isolation_chk: assert property (@(posedge clk) disable iff (rst)
    scr_wr |=> $stable(prg_win) && $stable(chr_slot));

  // R8
  chr_pair_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr && (sel_q == 3'd0) |=>
      (chr_slot[5] == chr_slot[4] + 9'd1) && chr_slot[4][8] && !chr_slot[4][0]);

endmodule

bind prg_override_ctl prg_override_chk #(.PRG_BANKS(PRG_BANKS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .prg_win   (prg_win),
  .chr_slot  (chr_slot),
  .mode_on   (u_map.mode_on_q),
  .mode_wide (u_map.mode_wide_q),
  .sel_q     (sel_q)
);

// File: tb/tb_prg_override_ctl.sv
module tb_prg_override_ctl;

  localparam int PB = 64;
  localparam int BW = 6;
  localparam int AW = 10;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 wr_en = 1'b0;
  logic [15:0]          wr_addr = '0;
  logic [7:0]           wr_data = '0;
  logic [AW-1:0]        scr_rd_addr = '0;
  logic [7:0]           scr_rd_data;
  logic [3:0][BW-1:0]   prg_win;
  logic [7:0][8:0]      chr_slot;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  prg_override_ctl #(.PRG_BANKS(PB), .SCR_AW(AW)) dut (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .scr_rd_addr (scr_rd_addr),
    .scr_rd_data (scr_rd_data),
    .prg_win     (prg_win),
    .chr_slot    (chr_slot)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_wins(input string req, input int w0, input int w1, input int w2, input int w3);
    chk(req, "win0", int'(prg_win[0]), w0);
    chk(req, "win1", int'(prg_win[1]), w1);
    chk(req, "win2", int'(prg_win[2]), w2);
    chk(req, "win3", int'(prg_win[3]), w3);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_wins("R1", PB-4, PB-3, PB-2, PB-1);
    for (int s = 0; s < 8; s++) chk("R1", "chr slot", int'(chr_slot[s]), 0);
  endtask

  task automatic t_direct;
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h45);
    chk_wins("R2", 8'h45 % PB, PB-3, PB-2, PB-1);
    wr(16'h8000, 8'h07); wr(16'h8001, 8'hFF);
    chk_wins("R2", 8'h45 % PB, 8'hFF % PB, PB-2, PB-1);
  endtask

  task automatic t_alias;
    wr(16'h9ABE, 8'h0E);
    wr(16'h9ABF, 8'h21);
    chk("R10", "aliased select 6 win0", int'(prg_win[0]), 8'h21);
    wr(16'hA001, 8'h03);
    wr(16'hC001, 8'h30);
    chk_wins("R10", 8'h21, 8'hFF % PB, PB-2, PB-1);
  endtask

  task automatic t_chr;
    wr(16'h8000, 8'h00); wr(16'h8001, 8'h13);
    chk("R8", "slot4", int'(chr_slot[4]), 9'h112);
    chk("R8", "slot5", int'(chr_slot[5]), 9'h113);
    wr(16'h8000, 8'h01); wr(16'h8001, 8'h80);
    chk("R8", "slot6", int'(chr_slot[6]), 9'h180);
    chk("R8", "slot7", int'(chr_slot[7]), 9'h181);
    for (int k = 0; k < 4; k++) begin
      wr(16'h8000, 8'(k + 2));
      wr(16'h8001, 8'(8'hA1 + k));
    end
    for (int k = 0; k < 4; k++) chk("R9", "low slot", int'(chr_slot[k]), 8'hA1 + k);
  endtask

  task automatic t_wide;
    wr(16'h5000, 8'hA7);
    chk_wins("R3", 12, 13, 14, 15);
  endtask

  task automatic t_lock;
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h11);
    wr(16'h8000, 8'h07); wr(16'h8001, 8'h22);
    chk_wins("R6", 12, 13, 14, 15);
  endtask

  task automatic t_fallback;
    wr(16'h5000, 8'h00);
    chk_wins("R5", 8'h11, 8'h22, PB-2, PB-1);
  endtask

  task automatic t_half;
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h03);
    wr(16'h5000, 8'h84);
    chk_wins("R4", 3, 8'h22, 8, 9);
    wr(16'h8000, 8'h07); wr(16'h8001, 8'h05);
    chk_wins("R2", 3, 5, 8, 9);
  endtask

  task automatic t_scratch;
    wr(16'h5001, 8'h5A);
    wr(16'h53FF, 8'hC3);
    wr(16'h5002, 8'hA6);
    chk_wins("R7", 3, 5, 8, 9);
    chk("R7", "slot4 kept", int'(chr_slot[4]), 9'h112);
    @(negedge clk); scr_rd_addr = AW'(1);
    @(negedge clk);
    chk("R7", "scratch 0x001", int'(scr_rd_data), 8'h5A);
    scr_rd_addr = AW'(10'h3FF);
    @(negedge clk);
    chk("R7", "scratch 0x3FF", int'(scr_rd_data), 8'hC3);
    scr_rd_addr = AW'(2);
    @(negedge clk);
    chk("R7", "scratch 0x002", int'(scr_rd_data), 8'hA6);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_alias();
    t_chr();
    t_wide();
    t_lock();
    t_fallback();
    t_half();
    t_scratch();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule